// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a multicycle processor core in which one memory serves both instruction and data traffic and a single ALU handles both datapath arithmetic and program-counter arithmetic. It reads the 6-bit opcode held in the instruction register and walks through one state per clock. Each state drives the select lines, write enables and ALU function code that the datapath needs in that cycle.

The number of cycles an instruction needs depends on its class. A load takes five cycles. A store or a register-register operation takes four. A conditional branch or an unconditional jump takes three. After the final state of any instruction the machine goes back to the fetch state.

The sequencer also combines its two PC write requests with the ALU zero flag to form the PC load strobe. All outputs are Moore outputs of the state, apart from that strobe and apart from the reset gating.

Top module: `mc_ctrl_seq`

## Requirements
- R1: When `rst_n` is low at a rising edge, the next state is fetch. While `rst_n` is low, every control output is driven to 0. The first cycle after `rst_n` returns high is a fetch cycle.
- R2: A fetch cycle drives the following: `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `iord`=0, `src_a`=0 (PC), `src_b`=01 (constant 4), `alu_op`=00 (add), `pc_src`=00 (ALU result). In every cycle, any select or enable that the cycle does not use is 0.
- R3: The cycle after every fetch is a decode cycle. It drives `src_a`=0 and `src_b`=11 (shifted immediate) with `alu_op`=00, so that the branch target is computed ahead of time. It asserts no enable.
- R4: A load (opcode 6'b100011) runs five cycles: fetch, decode, address, read, writeback. The address cycle drives `src_a`=1 (A), `src_b`=10 (immediate) and `alu_op`=00. The read cycle drives `iord`=1 and `mem_rd`=1. The writeback cycle drives `reg_wr`=1, `mem_to_reg`=1 and `reg_dst`=0.
- R5: A store (opcode 6'b101011) runs four cycles: fetch, decode, address (the same as the load address cycle), write. The write cycle drives `iord`=1 and `mem_wr`=1.
- R6: A register-register operation (opcode 6'b000000) runs four cycles: fetch, decode, execute, writeback. Execute drives `src_a`=1, `src_b`=00 (B) and `alu_op`=10 (function-field controlled). Writeback drives `reg_wr`=1 and `reg_dst`=1 (rd).
- R7: A branch-if-equal (opcode 6'b000100) runs three cycles: fetch, decode, compare. Compare drives `pc_wr_cond`=1, `src_a`=1, `src_b`=00, `alu_op`=01 (subtract) and `pc_src`=01 (ALUOut).
- R8: A jump (opcode 6'b000010) runs three cycles: fetch, decode, jump. The jump cycle drives `pc_wr`=1 and `pc_src`=10 (jump target).
- R9: Any other opcode goes from decode straight back to fetch. It asserts no register, memory or PC write after the fetch cycle.
- R10: The opcode is sampled only in the decode cycle. A change on `opcode` in later cycles of the same instruction does not alter its sequence.
- R11: `pc_load` is 1 exactly when `pc_wr` is 1, or when `pc_wr_cond` is 1 and `alu_zero` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional PC write request |
| pc_wr_cond | output | 1 | PC write request when the ALU result is zero |
| pc_load | output | 1 | Combined PC load strobe |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALUOut |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 = ALUOut, 1 = memory data register |
| reg_dst | output | 1 | Destination register: 0 = rt, 1 = rd |
| reg_wr | output | 1 | Register file write |
| src_a | output | 1 | ALU operand A: 0 = PC, 1 = A register |
| src_b | output | 2 | ALU operand B: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the five standard class codes. It then runs each class back to back, takes both branch outcomes and drives two unassigned opcodes. It changes the opcode after decode to show that the latched class is the one in control, and it asserts reset in the middle of a load. With these defaults every state and every transition of the machine can be reached, including the two-cycle path for an unknown opcode and a reset arriving mid-instruction.

// File: rtl/mcs_pkg.sv
// Shared types for the multicycle control sequencer.
// Assumes: select fields are two bits wide, as the datapath muxes expect.
package mcs_pkg;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_LDRD, ST_LDWB,
        ST_STWR, ST_EXE, ST_RWB, ST_BRN, ST_JMP
    } state_t;

    typedef enum logic [2:0] {
        CL_NONE, CL_ALU, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP
    } iclass_t;

    localparam logic [1:0] SB_REG   = 2'b00;
    localparam logic [1:0] SB_FOUR  = 2'b01;
    localparam logic [1:0] SB_IMM   = 2'b10;
    localparam logic [1:0] SB_IMMX4 = 2'b11;

    localparam logic [1:0] AOP_ADD  = 2'b00;
    localparam logic [1:0] AOP_SUB  = 2'b01;
    localparam logic [1:0] AOP_FUNC = 2'b10;

    localparam logic [1:0] PS_ALU   = 2'b00;
    localparam logic [1:0] PS_OUT   = 2'b01;
    localparam logic [1:0] PS_JMP   = 2'b10;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       iord;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       reg_wr;
        logic       src_a;
        logic [1:0] src_b;
        logic [1:0] alu_op;
        logic [1:0] pc_src;
    } ctrl_t;

endpackage

// File: rtl/mcs_op_class.sv
// Opcode classifier: maps the opcode field onto an instruction class.
// Assumes: opcode codes are distinct; anything unmatched is CL_NONE.
module mcs_op_class
    import mcs_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic [OP_W-1:0] op,
    output iclass_t         cls
);

    // Compare the opcode against each supported code.
    always_comb begin
        if      (op == OP_RTYPE)  cls = CL_ALU;
        else if (op == OP_LOAD)   cls = CL_LOAD;
        else if (op == OP_STORE)  cls = CL_STORE;
        else if (op == OP_BRANCH) cls = CL_BRANCH;
        else if (op == OP_JUMP)   cls = CL_JUMP;
        else                      cls = CL_NONE;
    end

endmodule

// File: rtl/mcs_next_state.sv
// Next-state function of the sequencer.
// Assumes: cls is valid in the decode state and holds steady after it.
module mcs_next_state
    import mcs_pkg::*;
(
    input  state_t  cur,
    input  iclass_t cls,
    output state_t  nxt
);

    // Dispatch on class at decode; every final phase returns to fetch.
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_LOAD, CL_STORE: nxt = ST_ADDR;
                    CL_ALU:            nxt = ST_EXE;
                    CL_BRANCH:         nxt = ST_BRN;
                    CL_JUMP:           nxt = ST_JMP;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:   nxt = (cls == CL_LOAD) ? ST_LDRD : ST_STWR;
            ST_LDRD:   nxt = ST_LDWB;
            ST_EXE:    nxt = ST_RWB;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcs_ctrl_rom.sv
// State-to-control decoder: the Moore output word for each state.
// Assumes: fields not used by a state are held at 0.
module mcs_ctrl_rom
    import mcs_pkg::*;
(
    input  state_t st,
    output ctrl_t  c
);

    // Build the control word for the present state.
    always_comb begin
        c = '0;
        unique case (st)
            ST_FETCH: begin
                c.mem_rd = 1'b1;
                c.ir_wr  = 1'b1;
                c.pc_wr  = 1'b1;
                c.src_b  = SB_FOUR;
                c.alu_op = AOP_ADD;
                c.pc_src = PS_ALU;
            end
            ST_DECODE: begin
                c.src_b  = SB_IMMX4;
                c.alu_op = AOP_ADD;
            end
            ST_ADDR: begin
                c.src_a  = 1'b1;
                c.src_b  = SB_IMM;
                c.alu_op = AOP_ADD;
            end
            ST_LDRD: begin
                c.iord   = 1'b1;
                c.mem_rd = 1'b1;
            end
            ST_LDWB: begin
                c.reg_wr     = 1'b1;
                c.mem_to_reg = 1'b1;
            end
            ST_STWR: begin
                c.iord   = 1'b1;
                c.mem_wr = 1'b1;
            end
            ST_EXE: begin
                c.src_a  = 1'b1;
                c.src_b  = SB_REG;
                c.alu_op = AOP_FUNC;
            end
            ST_RWB: begin
                c.reg_wr  = 1'b1;
                c.reg_dst = 1'b1;
            end
            ST_BRN: begin
                c.pc_wr_cond = 1'b1;
                c.src_a      = 1'b1;
                c.src_b      = SB_REG;
                c.alu_op     = AOP_SUB;
                c.pc_src     = PS_OUT;
            end
            ST_JMP: begin
                c.pc_wr  = 1'b1;
                c.pc_src = PS_JMP;
            end
            default: c = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
// Multicycle control sequencer top: state register, latched instruction
// class, output decode and the PC load strobe.
// Assumes: opcode comes from the instruction register and is valid in the
// decode cycle; reset is synchronous and active low.
module mc_ctrl_seq
    import mcs_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            pc_load,
    output logic            iord,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            mem_to_reg,
    output logic            reg_dst,
    output logic            reg_wr,
    output logic            src_a,
    output logic [1:0]      src_b,
    output logic [1:0]      alu_op,
    output logic [1:0]      pc_src
);

    state_t  state_q, state_d;
    iclass_t cls_now, cls_q, cls_use;
    ctrl_t   ctrl_raw, ctrl;

    mcs_op_class #(
        .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
        .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
    ) u_class (
        .op  (opcode),
        .cls (cls_now)
    );

    // Live class in decode, latched class for the remaining phases.
    always_comb cls_use = (state_q == ST_DECODE) ? cls_now : cls_q;

    mcs_next_state u_next (
        .cur (state_q),
        .cls (cls_use),
        .nxt (state_d)
    );

    mcs_ctrl_rom u_rom (
        .st (state_q),
        .c  (ctrl_raw)
    );

    // State register and class latch, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            cls_q   <= CL_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DECODE) cls_q <= cls_now;
        end
    end

    // Hold every control line low while reset is asserted.
    always_comb ctrl = rst_n ? ctrl_raw : '0;

    // Drive the individual control ports.
    always_comb begin
        pc_wr      = ctrl.pc_wr;
        pc_wr_cond = ctrl.pc_wr_cond;
        iord       = ctrl.iord;
        mem_rd     = ctrl.mem_rd;
        mem_wr     = ctrl.mem_wr;
        ir_wr      = ctrl.ir_wr;
        mem_to_reg = ctrl.mem_to_reg;
        reg_dst    = ctrl.reg_dst;
        reg_wr     = ctrl.reg_wr;
        src_a      = ctrl.src_a;
        src_b      = ctrl.src_b;
        alu_op     = ctrl.alu_op;
        pc_src     = ctrl.pc_src;
        pc_load    = ctrl.pc_wr | (ctrl.pc_wr_cond & alu_zero);
    end

endmodule

// File: rtl/mcs_ctrl_seq_chk.sv
// Property checker for the control sequencer, bound to the top module.
// Assumes: observes ports only.
module mcs_ctrl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alu_zero,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       pc_load,
    input logic       iord,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       mem_to_reg,
    input logic       reg_wr,
    input logic [1:0] pc_src
);

    // R1: all enables quiet while reset is held.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !(pc_wr || pc_wr_cond || pc_load || mem_rd || mem_wr || ir_wr || reg_wr));

    // R3: the cycle after a fetch writes nothing.
    a_r3_decode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> !(ir_wr || reg_wr || mem_wr || pc_wr || pc_wr_cond));

    // R4: a data read is followed by a memory-sourced register write.
    a_r4_read_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && iord) |=> (reg_wr && mem_to_reg));

    // R5: a memory write ends the instruction.
    a_r5_store_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_wr);

    // R7: a branch compare ends the instruction.
    a_r7_branch_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> ir_wr);

    // R8: a jump ends the instruction.
    a_r8_jump_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'b10) |=> ir_wr);

    // R9: at most one of the storage writes in any cycle.
    a_r9_single_store: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, reg_wr, ir_wr}));

    // R11: a conditional request with zero clear never loads the PC.
    a_r11_cond_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && !alu_zero && !pc_wr) |-> !pc_load);

endmodule

bind mc_ctrl_seq mcs_ctrl_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_zero   (alu_zero),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_load    (pc_load),
    .iord       (iord),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_wr      (ir_wr),
    .mem_to_reg (mem_to_reg),
    .reg_wr     (reg_wr),
    .pc_src     (pc_src)
);

// File: tb/mc_ctrl_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: builds the expected control word for each cycle from the
// requirements into a queue and compares it with the ports every cycle.
module mc_ctrl_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic       alu_zero = 1'b0;
    logic       pc_wr, pc_wr_cond, pc_load, iord, mem_rd, mem_wr, ir_wr;
    logic       mem_to_reg, reg_dst, reg_wr, src_a;
    logic [1:0] src_b, alu_op, pc_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mc_ctrl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_load(pc_load),
        .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .reg_wr(reg_wr),
        .src_a(src_a), .src_b(src_b), .alu_op(alu_op), .pc_src(pc_src)
    );

    localparam logic [5:0] C_R  = 6'b000000;
    localparam logic [5:0] C_LW = 6'b100011;
    localparam logic [5:0] C_SW = 6'b101011;
    localparam logic [5:0] C_BQ = 6'b000100;
    localparam logic [5:0] C_J  = 6'b000010;

    // Control word order: pc_wr pc_wr_cond iord mem_rd mem_wr ir_wr
    // mem_to_reg reg_dst reg_wr src_a src_b alu_op pc_src pc_load
    function automatic logic [16:0] mk(input bit pw, pc, io, mr, mw, iw, m2r, rd, rw, sa,
                                       input logic [1:0] sb, ao, ps, input bit pl);
        return {pw, pc, io, mr, mw, iw, m2r, rd, rw, sa, sb, ao, ps, pl};
    endfunction

    function automatic logic [16:0] actual();
        return {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg,
                reg_dst, reg_wr, src_a, src_b, alu_op, pc_src, pc_load};
    endfunction

    task automatic check(input logic [16:0] exp, input string tag);
        n_chk++;
        if (actual() !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%05h expected=%05h at %0t", tag, actual(), exp, $time);
        end
    endtask

    // Hold reset for n cycles; outputs must all be zero (R1).
    task automatic hold_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            #1;
            check('0, "R1 reset quiet");
        end
    endtask

    // Run one instruction; late_op is driven from the third cycle on;
    // stop_at > 0 truncates the run after that many cycles.
    task automatic run_instr(input logic [5:0] op, input logic [5:0] late_op,
                             input bit z, input int stop_at);
        logic [16:0] eq[$];
        string       tq[$];
        eq.push_back(mk(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00,1)); tq.push_back("R2 R11 fetch");
        eq.push_back(mk(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00,0)); tq.push_back("R3 decode");
        if (op == C_LW) begin
            eq.push_back(mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0)); tq.push_back("R4 R10 address");
            eq.push_back(mk(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00,0)); tq.push_back("R4 R10 read");
            eq.push_back(mk(0,0,0,0,0,0,1,0,1,0,2'b00,2'b00,2'b00,0)); tq.push_back("R4 R10 writeback");
        end else if (op == C_SW) begin
            eq.push_back(mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0)); tq.push_back("R5 R10 address");
            eq.push_back(mk(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00,0)); tq.push_back("R5 R10 write");
        end else if (op == C_R) begin
            eq.push_back(mk(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00,0)); tq.push_back("R6 R10 execute");
            eq.push_back(mk(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00,0)); tq.push_back("R6 R10 writeback");
        end else if (op == C_BQ) begin
            eq.push_back(mk(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01,z)); tq.push_back("R7 R11 compare");
        end else if (op == C_J) begin
            eq.push_back(mk(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10,1)); tq.push_back("R8 jump");
        end
        // unknown opcode (R9): nothing after decode, next cycle is fetch
        for (int i = 0; i < eq.size(); i++) begin
            if (stop_at > 0 && i >= stop_at) break;
            @(negedge clk);
            rst_n    = 1'b1;
            opcode   = (i < 2) ? op : late_op;
            alu_zero = z;
            #1;
            check(eq[i], tq[i]);
        end
    endtask

    initial begin
        hold_reset(3);
        run_instr(C_LW, C_LW, 1'b0, 0);
        run_instr(C_SW, C_SW, 1'b1, 0);
        run_instr(C_R,  C_R,  1'b0, 0);
        run_instr(C_BQ, C_BQ, 1'b1, 0);
        run_instr(C_BQ, C_BQ, 1'b0, 0);
        run_instr(C_J,  C_J,  1'b0, 0);
        run_instr(6'h3f, 6'h3f, 1'b1, 0);   // R9
        run_instr(6'h08, C_LW, 1'b0, 0);    // R9 with a load opcode arriving late
        run_instr(C_LW, C_SW, 1'b0, 0);     // R10
        run_instr(C_SW, C_LW, 1'b0, 0);     // R10
        run_instr(C_R,  C_BQ, 1'b1, 0);     // R10
        run_instr(C_BQ, C_J,  1'b0, 0);     // R10
        run_instr(C_LW, C_LW, 1'b0, 3);     // reset mid-load (R1)
        hold_reset(2);
        run_instr(C_J, C_J, 1'b1, 0);
        for (int k = 0; k < 40; k++) begin
            case (k % 6)
                0: run_instr(C_R,  C_R,  k[0], 0);
                1: run_instr(C_LW, C_LW, k[1], 0);
                2: run_instr(C_BQ, C_BQ, k[1], 0);
                3: run_instr(C_SW, C_SW, k[0], 0);
                4: run_instr(6'h11, 6'h11, k[0], 0);
                default: run_instr(C_J, C_J, k[2], 0);
            endcase
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule